// File: doc/BRIEF.md
# Wavelet Tree Maximum-Magnitude Scanner

This block walks the spatial-orientation trees of a square wavelet image, one 2x2 coefficient block at a time, and reports how large the coefficients under each block are. It reads blocks from a memory with a 32-bit read port. Each access returns two 16-bit coefficients, which are half of a block. For every block it emits the largest magnitude in each of the four subtrees hanging from its pixels, and the largest magnitude in the whole block including those subtrees. It also emits the sign bit and a significance flag for each of the sixteen coefficients in its four child blocks. A later bit-plane coder can then decide set significance for every block on its own.

Blocks are numbered by their Morton index in block coordinates. Block `m` has child blocks `4m..4m+3`. Block 0 is the root, and its upper-left pixel has no offspring. Blocks are visited in post-order: all descendants of a block are read and reduced before the block itself. The result address is the Morton index, so each tree level falls into its own contiguous address range. Reading the result store upward from address 0 therefore gives coarsest-to-finest Morton order. Each level keeps a four-entry stack holding the most recent child results, so a parent sees its children's maxima, signs and flags when it is visited.

Top module: `tree_max_scan`

## Requirements
- R1: After reset, `busy`, `rd_en`, `out_valid` and `done` are low.
- R2: A `start` pulse while `busy` is low begins one full scan. A `start` pulse while `busy` is high has no effect: the running scan still produces each block exactly once and a single `done`.
- R3: Block `m` occupies word `2m` (top row: pixel 0 in bits W-1:0, pixel 1 in bits 2W-1:W) and word `2m+1` (bottom row: pixel 2 low, pixel 3 high). Each block is read as word `2m` followed in the next cycle by word `2m+1`. Read data returns one cycle after `rd_en`.
- R4: Results come out in post-order. Every block is emitted exactly once, after all blocks in its subtree. The root, index 0, is emitted last, together with `done`.
- R5: `out_addr` is the block's Morton index. Level 0 is index 0, and level l >= 1 holds the indices in [4^(l-1), 4^l). `out_level` gives the level of the emitted block.
- R6: Lane k of `out_sub_max` (bits k*W +: W) is the largest magnitude in the subtree rooted at child block `4m+k`. Magnitude is the absolute value of the two's-complement coefficient, so the most negative code has magnitude 2^(W-1).
- R7: `out_blk_max` is the largest of the block's own four magnitudes and its four `out_sub_max` lanes.
- R8: Blocks at the finest level (level LOG_N-1) report zero in every `out_sub_max` lane, `out_kid_sign` and `out_kid_sig`.
- R9: For the root block, lane 0 of `out_sub_max` and bits 3:0 of `out_kid_sign` and `out_kid_sig` are zero, whatever the root's own coefficients are.
- R10: Bit 4k+j of `out_kid_sign` is the sign bit of pixel j of child block `4m+k`. The same bit of `out_kid_sig` is 1 when that pixel's magnitude shifted right by `plane` is nonzero.
- R11: One block result is produced every two cycles. The root appears with `done` 2*4^(LOG_N-1)+2 cycles after the cycle in which `start` was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| plane | input | $clog2(W) | Bit plane used for the child significance flags |
| rd_en | output | 1 | Coefficient memory read enable |
| rd_addr | output | 2*(LOG_N-1)+1 | Word address: block index and row |
| rd_data | input | 2*W | Two coefficients, returned one cycle after the read |
| busy | output | 1 | Scan in progress |
| out_valid | output | 1 | Block result valid |
| out_addr | output | 2*(LOG_N-1) | Morton index of the block, used as result address |
| out_level | output | $clog2(LOG_N) | Tree level of the block |
| out_blk_max | output | W | Largest magnitude of block and subtrees |
| out_sub_max | output | 4*W | Per-pixel subtree maxima, lane k for pixel k |
| out_kid_sign | output | 16 | Sign bits of the sixteen child coefficients |
| out_kid_sig | output | 16 | Significance flags of the sixteen child coefficients |
| done | output | 1 | Final (root) result of the scan |

## Verification
Two functions can fall in the same cycle:
- The reduction and emission of one block, using the second half-word that arrives that cycle.
- The address issue for the next block's first half.

On an ascent, the parent is also reduced only two cycles after its last child was pushed onto the level stack. The bench provokes the tightest case with a single spike in the last pixel of block 47. The ascent 47 → 11 → 2 then runs back-to-back, and the spike's magnitude must appear in each of those ancestors and in the root. Every run is judged on the exact cycle of `done` and on the full per-block results, which the bench computes from its own copy of the coefficients.

// File: rtl/tree_max_scan.sv
module tree_max_scan #(
  parameter int LOG_N = 4,
  parameter int W = 16,
  localparam int L = LOG_N - 1,
  localparam int NW = 2 * L,
  localparam int AW = NW + 1,
  localparam int LW = $clog2(LOG_N),
  localparam int PW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW-1:0]   plane,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  input  logic [2*W-1:0]  rd_data,
  output logic            busy,
  output logic            out_valid,
  output logic [NW-1:0]   out_addr,
  output logic [LW-1:0]   out_level,
  output logic [W-1:0]    out_blk_max,
  output logic [4*W-1:0]  out_sub_max,
  output logic [15:0]     out_kid_sign,
  output logic [15:0]     out_kid_sig,
  output logic            done
);
  localparam logic [NW-1:0] FIRST = NW'(1) << (2 * (L - 1));

  logic            iss, ph, pend;
  logic [NW-1:0]   m, cm;
  logic [LW-1:0]   cl, kl;
  logic [2*W-1:0]  lo;
  logic [W-1:0]    smax [LOG_N][4];
  logic [3:0]      ssgn [LOG_N][4];
  logic [3:0]      ssig [LOG_N][4];

  function automatic logic [LW-1:0] lvl_of(input logic [NW-1:0] x);
    lvl_of = '0;
    for (int l = 1; l <= L; l++)
      if (x >= (NW'(1) << (2 * (l - 1)))) lvl_of = LW'(l);
  endfunction

  function automatic logic [NW-1:0] next_of(input logic [NW-1:0] x);
    if (x[1:0] == 2'b11) next_of = x >> 2;
    else next_of = (x + NW'(1)) << (2 * (L - int'(lvl_of(x))));
  endfunction

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    mag = v[W-1] ? (~v + 1'b1) : v;
  endfunction

  assign rd_en   = iss;
  assign rd_addr = {m, ph};
  assign kl      = cl + 1'b1;

  logic [W-1:0] px [4];
  logic [W-1:0] kmax [4];
  logic [W-1:0] bmax;
  logic [15:0]  ksgn, ksig;
  logic [3:0]   osgn, osig;

  always_comb begin
    px[0] = lo[W-1:0];
    px[1] = lo[2*W-1:W];
    px[2] = rd_data[W-1:0];
    px[3] = rd_data[2*W-1:W];
    bmax = '0;
    ksgn = '0;
    ksig = '0;
    for (int k = 0; k < 4; k++) begin
      kmax[k] = '0;
      if (cl != LW'(L) && !(cm == '0 && k == 0)) begin
        kmax[k] = smax[kl][k];
        ksgn[4*k +: 4] = ssgn[kl][k];
        ksig[4*k +: 4] = ssig[kl][k];
      end
      osgn[k] = px[k][W-1];
      osig[k] = (mag(px[k]) >> plane) != '0;
      if (mag(px[k]) > bmax) bmax = mag(px[k]);
      if (kmax[k] > bmax) bmax = kmax[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss <= 1'b0; ph <= 1'b0; pend <= 1'b0; busy <= 1'b0;
      m <= '0; cm <= '0; cl <= '0; lo <= '0;
      out_valid <= 1'b0; done <= 1'b0; out_addr <= '0; out_level <= '0;
      out_blk_max <= '0; out_sub_max <= '0; out_kid_sign <= '0; out_kid_sig <= '0;
      for (int l = 0; l < LOG_N; l++)
        for (int k = 0; k < 4; k++) begin
          smax[l][k] <= '0; ssgn[l][k] <= '0; ssig[l][k] <= '0;
        end
    end else begin
      out_valid <= 1'b0;
      done <= 1'b0;
      if (pend) begin
        pend <= 1'b0;
        out_valid <= 1'b1;
        out_addr <= cm;
        out_level <= cl;
        out_blk_max <= bmax;
        for (int k = 0; k < 4; k++) out_sub_max[k*W +: W] <= kmax[k];
        out_kid_sign <= ksgn;
        out_kid_sig <= ksig;
        smax[cl][cm[1:0]] <= bmax;
        ssgn[cl][cm[1:0]] <= osgn;
        ssig[cl][cm[1:0]] <= osig;
        if (cm == '0) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end
      if (start && !busy) begin
        busy <= 1'b1;
        iss <= 1'b1;
        ph <= 1'b0;
        m <= FIRST;
      end else if (iss) begin
        ph <= ~ph;
        if (ph) begin
          lo <= rd_data;
          cm <= m;
          cl <= lvl_of(m);
          pend <= 1'b1;
          if (m == '0) iss <= 1'b0;
          else m <= next_of(m);
        end
      end
    end
  end
endmodule

// File: rtl/tree_max_scan_chk.sv
module tree_max_scan_chk #(
  parameter int LOG_N = 4,
  parameter int W = 16,
  localparam int L = LOG_N - 1,
  localparam int NW = 2 * L,
  localparam int AW = NW + 1,
  localparam int LW = $clog2(LOG_N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           rd_en,
  input logic [AW-1:0]  rd_addr,
  input logic           out_valid,
  input logic [NW-1:0]  out_addr,
  input logic [LW-1:0]  out_level,
  input logic [W-1:0]   out_blk_max,
  input logic [4*W-1:0] out_sub_max,
  input logic [15:0]    out_kid_sign,
  input logic [15:0]    out_kid_sig,
  input logic           done
);
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en); // R2

  AST_PAIRED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_addr[0] |=> rd_en && rd_addr[0] && (rd_addr[AW-1:1] == $past(rd_addr[AW-1:1]))); // R3

  AST_ROOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && out_addr == '0); // R4

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_level != '0 |-> (int'(out_addr) >= (1 << (2 * (int'(out_level) - 1))))
                                  && (int'(out_addr) < (1 << (2 * int'(out_level))))); // R5

  AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_blk_max >= out_sub_max[W-1:0] && out_blk_max >= out_sub_max[2*W-1:W]
               && out_blk_max >= out_sub_max[3*W-1:2*W] && out_blk_max >= out_sub_max[4*W-1:3*W]); // R7

  AST_LEAF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_level == LW'(L) |-> out_sub_max == '0 && out_kid_sign == '0 && out_kid_sig == '0); // R8

  AST_ROOT_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_addr == '0 |-> out_sub_max[W-1:0] == '0 && out_kid_sign[3:0] == '0
                                  && out_kid_sig[3:0] == '0); // R9

  AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
endmodule

bind tree_max_scan tree_max_scan_chk #(.LOG_N(LOG_N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
  .out_valid(out_valid), .out_addr(out_addr), .out_level(out_level),
  .out_blk_max(out_blk_max), .out_sub_max(out_sub_max),
  .out_kid_sign(out_kid_sign), .out_kid_sig(out_kid_sig), .done(done)
);

// File: tb/tree_max_scan_tb.sv
module tree_max_scan_tb;
  localparam int LOG_N = 4;
  localparam int W = 16;
  localparam int L = LOG_N - 1;
  localparam int NB = 4 ** L;
  localparam int NW = 2 * L;
  localparam int AW = NW + 1;
  localparam int LW = $clog2(LOG_N);
  localparam int PW = $clog2(W);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, rd_en, busy, out_valid, done;
  logic [PW-1:0] plane;
  logic [AW-1:0] rd_addr;
  logic [2*W-1:0] rd_data;
  logic [NW-1:0] out_addr;
  logic [LW-1:0] out_level;
  logic [W-1:0] out_blk_max;
  logic [4*W-1:0] out_sub_max;
  logic [15:0] out_kid_sign, out_kid_sig;

  tree_max_scan #(.LOG_N(LOG_N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .plane(plane), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .out_valid(out_valid),
    .out_addr(out_addr), .out_level(out_level), .out_blk_max(out_blk_max),
    .out_sub_max(out_sub_max), .out_kid_sign(out_kid_sign), .out_kid_sig(out_kid_sig),
    .done(done)
  );

  logic [2*W-1:0] mem [2*NB];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  logic [W-1:0] coef [NB][4];
  int ref_max [NB];
  int seen [NB], pos [NB], got_lvl [NB];
  logic [W-1:0] got_max [NB];
  logic [4*W-1:0] got_sub [NB];
  logic [15:0] got_sgn [NB], got_sig [NB];
  int nout, ndone, done_cyc, late_valid, last_addr;
  int checks = 0, fails = 0;

  function automatic int tmag(input logic [W-1:0] v);
    return v[W-1] ? (1 << W) - int'(v) : int'(v);
  endfunction

  function automatic int tlvl(input int x);
    int l = 1;
    if (x == 0) return 0;
    while (x >= 4 ** l) l++;
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load();
    for (int b = 0; b < NB; b++) begin
      mem[2*b]   = {coef[b][1], coef[b][0]};
      mem[2*b+1] = {coef[b][3], coef[b][2]};
    end
  endtask

  task automatic run(input int pl, input int poke);
    int cyc;
    for (int b = 0; b < NB; b++) seen[b] = 0;
    nout = 0; ndone = 0; done_cyc = -1; late_valid = 0; last_addr = -1;
    load();
    @(negedge clk); plane = PW'(pl); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (cyc < 2000 && (done_cyc < 0 || cyc < done_cyc + 8)) begin
      if (out_valid) begin
        if (done_cyc >= 0) late_valid++;
        seen[out_addr]++;
        pos[out_addr] = nout++;
        last_addr = int'(out_addr);
        got_lvl[out_addr] = int'(out_level);
        got_max[out_addr] = out_blk_max;
        got_sub[out_addr] = out_sub_max;
        got_sgn[out_addr] = out_kid_sign;
        got_sig[out_addr] = out_kid_sig;
      end
      if (done) begin
        ndone++;
        if (done_cyc < 0) done_cyc = cyc;
      end
      start = (cyc == poke);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  task automatic verify(input int pl, input string tag);
    for (int b = NB - 1; b >= 0; b--) begin
      ref_max[b] = 0;
      for (int j = 0; j < 4; j++) if (tmag(coef[b][j]) > ref_max[b]) ref_max[b] = tmag(coef[b][j]);
      if (tlvl(b) < L)
        for (int k = 0; k < 4; k++)
          if (!(b == 0 && k == 0) && ref_max[4*b+k] > ref_max[b]) ref_max[b] = ref_max[4*b+k];
    end
    chk(nout == NB, "R4", {tag, " result count"}, nout, NB);
    chk(ndone == 1 && late_valid == 0, "R4", {tag, " single done, nothing after"}, ndone + late_valid, 1);
    chk(last_addr == 0, "R4", {tag, " root emitted last"}, last_addr, 0);
    chk(done_cyc == 2*NB + 2, "R11", {tag, " done cycle"}, done_cyc, 2*NB + 2);
    for (int b = 0; b < NB; b++) begin
      bit leaf;
      logic [15:0] es, eg;
      leaf = (tlvl(b) == L);
      chk(seen[b] == 1, "R4", $sformatf("%s block %0d emitted once", tag, b), seen[b], 1);
      chk(got_lvl[b] == tlvl(b), "R5", $sformatf("%s block %0d level", tag, b), got_lvl[b], tlvl(b));
      chk(int'(got_max[b]) == ref_max[b], "R7", $sformatf("%s block %0d blk_max", tag, b), got_max[b], ref_max[b]);
      es = '0; eg = '0;
      for (int k = 0; k < 4; k++) begin
        int ex;
        int c;
        c = 4*b + k;
        ex = 0;
        if (!leaf && !(b == 0 && k == 0)) begin
          ex = ref_max[c];
          chk(pos[c] < pos[b], "R4", $sformatf("%s child %0d before %0d", tag, c, b), pos[c], pos[b]);
          for (int j = 0; j < 4; j++) begin
            es[4*k+j] = coef[c][j][W-1];
            eg[4*k+j] = (tmag(coef[c][j]) >> pl) != 0;
          end
        end
        chk(int'(got_sub[b][k*W +: W]) == ex, leaf ? "R8" : ((b == 0 && k == 0) ? "R9" : "R6"),
            $sformatf("%s block %0d sub lane %0d", tag, b, k), got_sub[b][k*W +: W], ex);
      end
      chk(got_sgn[b] == es, leaf ? "R8" : "R10", $sformatf("%s block %0d kid signs", tag, b), got_sgn[b], es);
      chk(got_sig[b] == eg, leaf ? "R8" : "R10", $sformatf("%s block %0d kid flags", tag, b), got_sig[b], eg);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; plane = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_en, "R1", "busy/rd_en in reset", {busy, rd_en}, 0);
    chk(!out_valid && !done, "R1", "valid/done in reset", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_en && !out_valid, "R1", "idle after reset", {busy, rd_en, out_valid}, 0);
  endtask

  task automatic t_random();
    for (int b = 0; b < NB; b++) for (int j = 0; j < 4; j++) coef[b][j] = W'($urandom);
    run(5, -1);
    verify(5, "random");
  endtask

  task automatic t_extreme();
    for (int b = 0; b < NB; b++) for (int j = 0; j < 4; j++) coef[b][j] = {1'b1, {(W-1){1'b0}}};
    run(15, -1);
    verify(15, "most-negative");
    chk(int'(got_max[0]) == (1 << (W-1)), "R6", "most-negative magnitude at root", got_max[0], 1 << (W-1));
  endtask

  task automatic t_spike();
    for (int b = 0; b < NB; b++) for (int j = 0; j < 4; j++) coef[b][j] = '0;
    coef[47][3] = -W'(1234);
    run(0, -1);
    verify(0, "spike");
    chk(int'(got_sub[2][3*W +: W]) == 1234, "R6", "spike in block 2 lane 3", got_sub[2][3*W +: W], 1234);
    chk(int'(got_sub[0][2*W +: W]) == 1234, "R6", "spike in root lane 2", got_sub[0][2*W +: W], 1234);
    chk(got_sgn[11][15] == 1'b1, "R10", "spike sign at block 11", got_sgn[11][15], 1);
  endtask

  task automatic t_root();
    for (int b = 0; b < NB; b++) for (int j = 0; j < 4; j++) coef[b][j] = W'($urandom_range(0, 100));
    for (int j = 0; j < 4; j++) coef[0][j] = -W'(30000);
    run(3, -1);
    verify(3, "root");
    chk(got_sub[0][W-1:0] == '0 && got_sgn[0][3:0] == '0, "R9", "root lane 0 empty",
        {got_sub[0][W-1:0], got_sgn[0][3:0]}, 0);
    chk(int'(got_max[0]) == 30000, "R7", "root own pixels dominate", got_max[0], 30000);
  endtask

  task automatic t_busy_start();
    for (int b = 0; b < NB; b++) for (int j = 0; j < 4; j++) coef[b][j] = W'($urandom);
    run(9, 40);
    verify(9, "start while busy R2");
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL R11 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_random();
    t_extreme();
    t_spike();
    t_root();
    t_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule